// File: doc/BRIEF.md
# Flash Chip-Erase and Lock-Bit Programming Sequencer

This controller sits on the programmer side of a flash device's command port and runs two complete flows on its own. A chip-erase request first writes zero into every cell, region by region. The encryption array goes first, then code memory, then the three lock bits. After that it runs erase attempts. Each attempt is followed by a read-back sweep in erase-verify mode. A lock request pulses a chosen subset of the three lock bits a fixed number of times and reads nothing back.

Every operation on the device port has the same shape. First comes a one-cycle command byte. Then the strobe is held high for a programmable number of clock cycles, and during the strobe a second byte is driven: a confirm code, or the data byte for a cell write. Read-back uses a separate read enable together with a region select and a cell address. The device returns the addressed byte on the same cycle. The host starts a flow with a one-cycle request. It watches `busy`, then reads `done`, `fail` and the number of erase attempts used.

Top module: `flash_erase_lock_seq`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `cmdLoad`, `strobe` and `rdEn` are low and `eraseTries` is zero.
- R2: An erase flow first writes zero to every cell. Each write is a command byte 50h (cell write), followed by a strobe that carries data byte 00h. The encryption array (region code 0) goes first in ascending address order, then code memory (region code 1) in ascending order, then lock bits 1, 2 and 3 (region code 2, addresses 0, 1, 2) in the lock-pulse form of R7.
- R3: The strobe stays high for exactly `strobeCycles` cycles, and for one cycle when that input is zero. The value is sampled when a request is accepted, and later changes have no effect on the flow in progress.
- R4: Each erase attempt issues command 20h, then a strobe carrying D0h, then command A0h. It then reads cells in the order encryption array, code memory, lock bits, each region in ascending address order, with `rdEn` high for one cycle per cell.
- R5: A read byte that is not FFh ends the sweep at that cell, and the next attempt begins. A sweep in which every byte is FFh ends the flow with `done` high, `fail` low and `eraseTries` equal to the number of attempts made.
- R6: If the sweep of attempt number MAX_TRIES (default 49) still finds a byte other than FFh, the flow ends with `done` and `fail` high and `eraseTries` equal to MAX_TRIES. No further attempt is made.
- R7: A lock request with `codeLoaded` high runs through the set bits of `lockMask`, lowest bit first. Bit k (0..2) stands for lock bit k+1. Each selected bit gets exactly 10 pulses, and each pulse is command 60h, 70h or 80h (for lock bit 1, 2 or 3) followed by a strobe carrying D0h. No reads are made. The flow then ends with `done` high and `fail` low. An empty mask finishes on the next cycle with no device activity.
- R8: A lock request made while `codeLoaded` is low is rejected. No device activity takes place, and on the next cycle `done` and `fail` are high and `busy` is low.
- R9: Requests made while `busy` is high are ignored. If both requests arrive in the same idle cycle, the erase flow runs and the lock request is dropped.
- R10: `busy` is high from the cycle after an accepted request until the flow ends. `done` is cleared when a request is accepted, and `done` and `busy` are never both high.
- R11: `cmdLoad`, `strobe` and `rdEn` are mutually exclusive, and the byte on `busByte` stays constant while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startErase | input | 1 | One-cycle request for the full erase flow |
| startLock | input | 1 | One-cycle request for lock-bit programming |
| lockMask | input | 3 | Lock bits to program; bit 0 is lock bit 1 |
| codeLoaded | input | 1 | Host indicates that encryption array and code memory are programmed |
| strobeCycles | input | WIDTH_W | Strobe width in clock cycles (zero is treated as one) |
| cmdLoad | output | 1 | First-cycle command byte valid on busByte |
| strobe | output | 1 | Program/erase strobe |
| rdEn | output | 1 | Erase-verify read of the addressed cell |
| busByte | output | 8 | Command, confirm or data byte |
| regionSel | output | 2 | Region: 0 encryption array, 1 code memory, 2 lock bits |
| cellAddr | output | ADDR_W | Cell address inside the selected region |
| rdData | input | 8 | Byte returned by the device for the addressed cell |
| busy | output | 1 | Flow in progress |
| done | output | 1 | Last flow finished; held until the next accepted request |
| fail | output | 1 | Last flow failed or was rejected; valid with done |
| eraseTries | output | TRIES_W | Erase attempts used by the last erase flow |

## Verification
Two things can fall in the same cycle. First, both requests can arrive in one idle cycle, and the bench drives exactly that. The scoreboard holds only the erase flow's operations, so any lock pulse left over from the dropped request shows up as an unexpected bus event. Second, a request can arrive while a flow is running. In the same run, a late lock request and a change of `strobeCycles` both land in the middle of the erase flow. The bench then checks that no extra operations appear and that every strobe keeps the width sampled when the request was accepted.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    REG_ENC  = 2'd0,
    REG_CODE = 2'd1,
    REG_LOCK = 2'd2
  } region_e;

  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_ERASE_VFY  = 8'hA0;
  localparam logic [7:0] DATA_ZERO      = 8'h00;
  localparam logic [7:0] ERASED_BYTE    = 8'hFF;
  localparam int         LOCK_COUNT     = 3;

  // Strobes from the control FSM to the datapath counters.
  typedef struct packed {
    logic    latchReq;
    logic    maskAll;
    logic    regionLoad;
    region_e regionVal;
    logic    addrInc;
    logic    useLockIdx;
    logic    pulseClr;
    logic    pulseInc;
    logic    strobeLoad;
    logic    triesClr;
    logic    triesInc;
    logic    lockPop;
  } path_ctrl_t;

  function automatic logic [7:0] lockCmd(input logic [1:0] idx);
    return 8'h60 + {2'b00, idx, 4'h0};
  endfunction

endpackage

// File: rtl/flash_seq_path.sv
module flash_seq_path
  import flash_seq_pkg::*;
#(
  parameter int ENC_DEPTH   = 16,
  parameter int CODE_DEPTH  = 64,
  parameter int WIDTH_W     = 8,
  parameter int MAX_TRIES   = 49,
  parameter int LOCK_PULSES = 10,
  parameter int ADDR_W      = 6,
  parameter int TRIES_W     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  path_ctrl_t         ctl,
  input  logic [WIDTH_W-1:0] strobeCycles,
  input  logic [2:0]         lockMask,
  input  logic [7:0]         rdData,
  output logic [1:0]         regionSel,
  output logic [ADDR_W-1:0]  cellAddr,
  output logic [1:0]         lockIdx,
  output logic [TRIES_W-1:0] eraseTries,
  output logic               addrLast,
  output logic               strobeLast,
  output logic               pulseLast,
  output logic               triesMax,
  output logic               lockMore,
  output logic               byteBad
);

  localparam int PULSE_W = (LOCK_PULSES > 1) ? $clog2(LOCK_PULSES) : 1;

  logic [WIDTH_W-1:0] widthReg;
  logic [WIDTH_W-1:0] strobeCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic [ADDR_W-1:0]  addrCnt;
  region_e            regionReg;
  logic [2:0]         remMask;
  logic [2:0]         lowBit;
  logic [TRIES_W-1:0] triesCnt;

  // Request latch: strobe width and remaining lock-bit set.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthReg <= '0;
      remMask  <= '0;
    end else begin
      if (ctl.latchReq) begin
        widthReg <= strobeCycles;
        remMask  <= ctl.maskAll ? 3'b111 : lockMask;
      end else if (ctl.lockPop) begin
        remMask <= remMask & ~lowBit;
      end
    end
  end

  assign lowBit   = remMask & (~remMask + 3'd1);
  assign lockMore = |(remMask & ~lowBit);

  always_comb begin
    lockIdx = 2'd0;
    for (int i = LOCK_COUNT - 1; i >= 0; i--) begin
      if (remMask[i]) lockIdx = 2'(i);
    end
  end

  // Strobe width counter: loaded with width-1, counts down to zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeCnt <= '0;
    end else if (ctl.strobeLoad) begin
      strobeCnt <= (widthReg == '0) ? '0 : widthReg - 1'b1;
    end else if (strobeCnt != '0) begin
      strobeCnt <= strobeCnt - 1'b1;
    end
  end

  assign strobeLast = (strobeCnt == '0);

  // Lock pulse repetition counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (ctl.pulseClr) begin
      pulseCnt <= '0;
    end else if (ctl.pulseInc) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  assign pulseLast = (pulseCnt == PULSE_W'(LOCK_PULSES - 1));

  // Region and address walker.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionReg <= REG_ENC;
      addrCnt   <= '0;
    end else if (ctl.regionLoad) begin
      regionReg <= ctl.regionVal;
      addrCnt   <= '0;
    end else if (ctl.addrInc) begin
      addrCnt <= addrCnt + 1'b1;
    end
  end

  always_comb begin
    unique case (regionReg)
      REG_ENC:  addrLast = (addrCnt == ADDR_W'(ENC_DEPTH - 1));
      REG_CODE: addrLast = (addrCnt == ADDR_W'(CODE_DEPTH - 1));
      default:  addrLast = (addrCnt == ADDR_W'(LOCK_COUNT - 1));
    endcase
  end

  assign regionSel = regionReg;
  assign cellAddr  = ctl.useLockIdx ? ADDR_W'(lockIdx) : addrCnt;

  // Erase attempt counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triesCnt <= '0;
    end else if (ctl.triesClr) begin
      triesCnt <= '0;
    end else if (ctl.triesInc) begin
      triesCnt <= triesCnt + 1'b1;
    end
  end

  assign eraseTries = triesCnt;
  assign triesMax   = (triesCnt == TRIES_W'(MAX_TRIES));
  assign byteBad    = (rdData != ERASED_BYTE);

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter logic [7:0] PROG_CMD = 8'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startErase,
  input  logic       startLock,
  input  logic [2:0] lockMask,
  input  logic       codeLoaded,
  input  logic [1:0] regionSel,
  input  logic [1:0] lockIdx,
  input  logic       addrLast,
  input  logic       strobeLast,
  input  logic       pulseLast,
  input  logic       triesMax,
  input  logic       lockMore,
  input  logic       byteBad,
  output path_ctrl_t ctl,
  output logic       cmdLoad,
  output logic       strobe,
  output logic       rdEn,
  output logic [7:0] busByte,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ZP_CMD, ST_ZP_STB, ST_LK_CMD, ST_LK_STB,
    ST_ER_CMD, ST_ER_STB, ST_EV_CMD, ST_EV_READ
  } state_e;

  state_e state, stateNext;
  logic   eraseMode, eraseModeNext;
  logic   doneSet, failSet, doneClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      eraseMode <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      state     <= stateNext;
      eraseMode <= eraseModeNext;
      if (doneSet) begin
        done <= 1'b1;
        fail <= failSet;
      end else if (doneClr) begin
        done <= 1'b0;
        fail <= 1'b0;
      end
    end
  end

  always_comb begin
    stateNext     = state;
    eraseModeNext = eraseMode;
    ctl           = '0;
    ctl.regionVal = REG_ENC;
    doneSet       = 1'b0;
    failSet       = 1'b0;
    doneClr       = 1'b0;
    ctl.useLockIdx = (state == ST_LK_CMD) || (state == ST_LK_STB);
    unique case (state)
      ST_IDLE: begin
        if (startErase) begin
          ctl.latchReq   = 1'b1;
          ctl.maskAll    = 1'b1;
          ctl.triesClr   = 1'b1;
          ctl.regionLoad = 1'b1;
          ctl.regionVal  = REG_ENC;
          doneClr        = 1'b1;
          eraseModeNext  = 1'b1;
          stateNext      = ST_ZP_CMD;
        end else if (startLock) begin
          if (!codeLoaded) begin
            doneSet = 1'b1;
            failSet = 1'b1;
          end else if (lockMask == 3'b000) begin
            doneSet = 1'b1;
          end else begin
            ctl.latchReq   = 1'b1;
            ctl.pulseClr   = 1'b1;
            ctl.regionLoad = 1'b1;
            ctl.regionVal  = REG_LOCK;
            doneClr        = 1'b1;
            eraseModeNext  = 1'b0;
            stateNext      = ST_LK_CMD;
          end
        end
      end
      ST_ZP_CMD: begin
        ctl.strobeLoad = 1'b1;
        stateNext      = ST_ZP_STB;
      end
      ST_ZP_STB: begin
        if (strobeLast) begin
          if (!addrLast) begin
            ctl.addrInc = 1'b1;
            stateNext   = ST_ZP_CMD;
          end else if (regionSel == REG_ENC) begin
            ctl.regionLoad = 1'b1;
            ctl.regionVal  = REG_CODE;
            stateNext      = ST_ZP_CMD;
          end else begin
            ctl.regionLoad = 1'b1;
            ctl.regionVal  = REG_LOCK;
            ctl.pulseClr   = 1'b1;
            stateNext      = ST_LK_CMD;
          end
        end
      end
      ST_LK_CMD: begin
        ctl.strobeLoad = 1'b1;
        stateNext      = ST_LK_STB;
      end
      ST_LK_STB: begin
        if (strobeLast) begin
          if (!pulseLast) begin
            ctl.pulseInc = 1'b1;
            stateNext    = ST_LK_CMD;
          end else begin
            ctl.pulseClr = 1'b1;
            ctl.lockPop  = 1'b1;
            if (lockMore) begin
              stateNext = ST_LK_CMD;
            end else if (eraseMode) begin
              stateNext = ST_ER_CMD;
            end else begin
              doneSet   = 1'b1;
              stateNext = ST_IDLE;
            end
          end
        end
      end
      ST_ER_CMD: begin
        ctl.triesInc   = 1'b1;
        ctl.strobeLoad = 1'b1;
        stateNext      = ST_ER_STB;
      end
      ST_ER_STB: begin
        if (strobeLast) stateNext = ST_EV_CMD;
      end
      ST_EV_CMD: begin
        ctl.regionLoad = 1'b1;
        ctl.regionVal  = REG_ENC;
        stateNext      = ST_EV_READ;
      end
      ST_EV_READ: begin
        if (byteBad) begin
          if (triesMax) begin
            doneSet   = 1'b1;
            failSet   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            stateNext = ST_ER_CMD;
          end
        end else if (!addrLast) begin
          ctl.addrInc = 1'b1;
        end else if (regionSel == REG_ENC) begin
          ctl.regionLoad = 1'b1;
          ctl.regionVal  = REG_CODE;
        end else if (regionSel == REG_CODE) begin
          ctl.regionLoad = 1'b1;
          ctl.regionVal  = REG_LOCK;
        end else begin
          doneSet   = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // Moore outputs toward the device port.
  always_comb begin
    cmdLoad = (state == ST_ZP_CMD) || (state == ST_LK_CMD) ||
              (state == ST_ER_CMD) || (state == ST_EV_CMD);
    strobe  = (state == ST_ZP_STB) || (state == ST_LK_STB) ||
              (state == ST_ER_STB);
    rdEn    = (state == ST_EV_READ);
    unique case (state)
      ST_ZP_CMD: busByte = PROG_CMD;
      ST_ZP_STB: busByte = DATA_ZERO;
      ST_LK_CMD: busByte = lockCmd(lockIdx);
      ST_LK_STB: busByte = CMD_CONFIRM;
      ST_ER_CMD: busByte = CMD_ERASE;
      ST_ER_STB: busByte = CMD_CONFIRM;
      ST_EV_CMD: busByte = CMD_ERASE_VFY;
      default:   busByte = 8'h00;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/flash_erase_lock_seq.sv
module flash_erase_lock_seq
  import flash_seq_pkg::*;
#(
  parameter int          ENC_DEPTH   = 16,
  parameter int          CODE_DEPTH  = 64,
  parameter int          WIDTH_W     = 8,
  parameter int          MAX_TRIES   = 49,
  parameter int          LOCK_PULSES = 10,
  parameter logic [7:0]  PROG_CMD    = 8'h50,
  localparam int         SPAN        = (ENC_DEPTH > CODE_DEPTH) ? ENC_DEPTH : CODE_DEPTH,
  localparam int         ADDR_W      = (SPAN > 4) ? $clog2(SPAN) : 2,
  localparam int         TRIES_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startErase,
  input  logic               startLock,
  input  logic [2:0]         lockMask,
  input  logic               codeLoaded,
  input  logic [WIDTH_W-1:0] strobeCycles,
  output logic               cmdLoad,
  output logic               strobe,
  output logic               rdEn,
  output logic [7:0]         busByte,
  output logic [1:0]         regionSel,
  output logic [ADDR_W-1:0]  cellAddr,
  input  logic [7:0]         rdData,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [TRIES_W-1:0] eraseTries
);

  path_ctrl_t ctl;
  logic [1:0] lockIdx;
  logic       addrLast, strobeLast, pulseLast, triesMax, lockMore, byteBad;

  flash_seq_ctrl #(.PROG_CMD(PROG_CMD)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .startErase(startErase), .startLock(startLock),
    .lockMask(lockMask), .codeLoaded(codeLoaded),
    .regionSel(regionSel), .lockIdx(lockIdx),
    .addrLast(addrLast), .strobeLast(strobeLast), .pulseLast(pulseLast),
    .triesMax(triesMax), .lockMore(lockMore), .byteBad(byteBad),
    .ctl(ctl), .cmdLoad(cmdLoad), .strobe(strobe), .rdEn(rdEn),
    .busByte(busByte), .busy(busy), .done(done), .fail(fail)
  );

  flash_seq_path #(
    .ENC_DEPTH(ENC_DEPTH), .CODE_DEPTH(CODE_DEPTH), .WIDTH_W(WIDTH_W),
    .MAX_TRIES(MAX_TRIES), .LOCK_PULSES(LOCK_PULSES),
    .ADDR_W(ADDR_W), .TRIES_W(TRIES_W)
  ) path_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .strobeCycles(strobeCycles), .lockMask(lockMask), .rdData(rdData),
    .regionSel(regionSel), .cellAddr(cellAddr), .lockIdx(lockIdx),
    .eraseTries(eraseTries),
    .addrLast(addrLast), .strobeLast(strobeLast), .pulseLast(pulseLast),
    .triesMax(triesMax), .lockMore(lockMore), .byteBad(byteBad)
  );

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
  parameter int MAX_TRIES = 49,
  parameter int TRIES_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               startErase,
  input logic               startLock,
  input logic               codeLoaded,
  input logic               cmdLoad,
  input logic               strobe,
  input logic               rdEn,
  input logic [7:0]         busByte,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [TRIES_W-1:0] eraseTries
);

  assert_port_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmdLoad, strobe, rdEn}) <= 1);

  assert_strobe_byte_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && $past(strobe)) |-> $stable(busByte));

  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  assert_erase_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startErase) |=> (busy && !done));

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startLock && !startErase && !codeLoaded) |=> (done && fail && !busy));

  assert_tries_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    eraseTries <= TRIES_W'(MAX_TRIES));

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(cmdLoad || strobe || rdEn));

endmodule

bind flash_erase_lock_seq flash_seq_checker #(
  .MAX_TRIES(MAX_TRIES), .TRIES_W(TRIES_W)
) checker_i (
  .clk(clk), .rstN(rstN), .startErase(startErase), .startLock(startLock),
  .codeLoaded(codeLoaded), .cmdLoad(cmdLoad), .strobe(strobe), .rdEn(rdEn),
  .busByte(busByte), .busy(busy), .done(done), .fail(fail),
  .eraseTries(eraseTries)
);

// File: tb/flash_erase_lock_seq_tb_top.sv
module flash_erase_lock_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ENC_N      = 4;
  localparam int CODE_N     = 8;
  localparam int MAXT       = 6;
  localparam int PULSES     = 10;
  localparam int STUCK      = 5;
  localparam int AW         = 3;
  localparam int TW         = 3;
  localparam logic [7:0] PROGC = 8'h50;

  localparam int K_CMD = 0;
  localparam int K_STB = 1;
  localparam int K_RD  = 2;

  typedef struct {
    int         kind;
    logic [7:0] byteV;
    int         region;
    int         addr;
    bit         chkLoc;
    int         width;
  } item_t;

  item_t expQ[$];
  int    errors = 0;
  int    checks = 0;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startErase = 1'b0;
  logic          startLock = 1'b0;
  logic [2:0]    lockMask = 3'b000;
  logic          codeLoaded = 1'b0;
  logic [7:0]    strobeCycles = 8'd1;
  logic          cmdLoad, strobe, rdEn, busy, done, fail;
  logic [7:0]    busByte;
  logic [1:0]    regionSel;
  logic [AW-1:0] cellAddr;
  logic [7:0]    rdData;
  logic [TW-1:0] eraseTries;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_erase_lock_seq #(
    .ENC_DEPTH(ENC_N), .CODE_DEPTH(CODE_N), .WIDTH_W(8),
    .MAX_TRIES(MAXT), .LOCK_PULSES(PULSES), .PROG_CMD(PROGC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startErase(startErase), .startLock(startLock),
    .lockMask(lockMask), .codeLoaded(codeLoaded), .strobeCycles(strobeCycles),
    .cmdLoad(cmdLoad), .strobe(strobe), .rdEn(rdEn), .busByte(busByte),
    .regionSel(regionSel), .cellAddr(cellAddr), .rdData(rdData),
    .busy(busy), .done(done), .fail(fail), .eraseTries(eraseTries)
  );

  // ---------------- behavioural device stub ----------------
  logic [7:0] encMem [ENC_N];
  logic [7:0] codeMem[CODE_N];
  logic [7:0] lockMem[3];
  logic [7:0] lastCmd;
  logic       stubPrev;
  logic       fillNow = 1'b0;
  int         eraseCount;
  int         eraseNeeded = 1;

  always @(posedge clk) begin
    if (fillNow) begin
      for (int i = 0; i < ENC_N; i++)  encMem[i]  <= 8'h5A;
      for (int i = 0; i < CODE_N; i++) codeMem[i] <= 8'h5A;
      for (int i = 0; i < 3; i++)      lockMem[i] <= 8'h5A;
      eraseCount <= 0;
      stubPrev   <= 1'b0;
    end else begin
      stubPrev <= strobe;
      if (cmdLoad) lastCmd <= busByte;
      if (strobe && !stubPrev) begin
        if (lastCmd == PROGC && busByte == 8'h00) begin
          if (regionSel == 2'd0) encMem[cellAddr] <= 8'h00;
          else if (regionSel == 2'd1) codeMem[cellAddr] <= 8'h00;
        end else if (lastCmd == 8'h60 || lastCmd == 8'h70 || lastCmd == 8'h80) begin
          lockMem[int'(cellAddr) % 3] <= 8'h00;
        end else if (lastCmd == 8'h20) begin
          eraseCount <= eraseCount + 1;
          for (int i = 0; i < ENC_N; i++)  encMem[i]  <= 8'hFF;
          for (int i = 0; i < CODE_N; i++) codeMem[i] <= 8'hFF;
          for (int i = 0; i < 3; i++)      lockMem[i] <= 8'hFF;
          if (eraseCount + 1 < eraseNeeded) codeMem[STUCK] <= 8'h00;
        end
      end
    end
  end

  always_comb begin
    if (regionSel == 2'd0)      rdData = encMem[int'(cellAddr) % ENC_N];
    else if (regionSel == 2'd1) rdData = codeMem[int'(cellAddr) % CODE_N];
    else                        rdData = lockMem[int'(cellAddr) % 3];
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic pushCmd(input logic [7:0] b, input int r, input int a, input bit loc);
    item_t it;
    it.kind = K_CMD; it.byteV = b; it.region = r; it.addr = a; it.chkLoc = loc; it.width = 0;
    expQ.push_back(it);
  endtask

  task automatic pushStb(input logic [7:0] b, input int w);
    item_t it;
    it.kind = K_STB; it.byteV = b; it.region = 0; it.addr = 0; it.chkLoc = 0; it.width = w;
    expQ.push_back(it);
  endtask

  task automatic pushRd(input int r, input int a);
    item_t it;
    it.kind = K_RD; it.byteV = 8'h00; it.region = r; it.addr = a; it.chkLoc = 1; it.width = 0;
    expQ.push_back(it);
  endtask

  task automatic pushLockBit(input int idx, input int w);
    for (int p = 0; p < PULSES; p++) begin
      pushCmd(8'h60 + 8'(idx * 16), 2, idx, 1);   // R7 lock pulse command
      pushStb(8'hD0, w);
    end
  endtask

  // ---------------- monitor ----------------
  logic prevStb = 1'b0;
  int   stbCnt = 0;
  int   stbExp = 0;

  task automatic popItem(output item_t it, output bit ok, input string req);
    ok = (expQ.size() != 0);
    check(ok, req, "unexpected bus activity", 1, 0);
    if (ok) it = expQ.pop_front();
  endtask

  always @(negedge clk) begin
    item_t it;
    bit    ok;
    if (!rstN) begin
      prevStb = 1'b0;
    end else begin
      if (cmdLoad) begin
        popItem(it, ok, "R2/R4/R7");
        if (ok) begin
          check(it.kind == K_CMD, "R2/R4/R7", "event kind (cmd)", K_CMD, it.kind);
          check(busByte == it.byteV, "R2/R4/R7", "command byte", busByte, it.byteV);
          if (it.chkLoc) begin
            check(regionSel == it.region, "R2", "command region", regionSel, it.region);
            check(cellAddr == it.addr, "R2", "command address", cellAddr, it.addr);
          end
        end
      end
      if (strobe && !prevStb) begin
        popItem(it, ok, "R3");
        if (ok) begin
          check(it.kind == K_STB, "R3", "event kind (strobe)", K_STB, it.kind);
          check(busByte == it.byteV, "R2/R4", "strobe byte", busByte, it.byteV);
          stbExp = it.width;
        end
        stbCnt = 1;
      end else if (strobe) begin
        stbCnt++;
      end
      if (!strobe && prevStb) check(stbCnt == stbExp, "R3", "strobe width", stbCnt, stbExp);
      if (rdEn) begin
        popItem(it, ok, "R4");
        if (ok) begin
          check(it.kind == K_RD, "R4", "event kind (read)", K_RD, it.kind);
          check(regionSel == it.region, "R4", "read region", regionSel, it.region);
          check(cellAddr == it.addr, "R4", "read address", cellAddr, it.addr);
        end
      end
      prevStb = strobe;
    end
  end

  // ---------------- scenarios ----------------
  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic resetDevice(input int needed);
    eraseNeeded = needed;
    fillNow = 1'b1;
    @(negedge clk);
    fillNow = 1'b0;
  endtask

  task automatic runErase(input int width, input int needed, input bit both);
    int w;
    int t;
    w = (width == 0) ? 1 : width;
    resetDevice(needed);
    for (int a = 0; a < ENC_N; a++)  begin pushCmd(PROGC, 0, a, 1); pushStb(8'h00, w); end
    for (int a = 0; a < CODE_N; a++) begin pushCmd(PROGC, 1, a, 1); pushStb(8'h00, w); end
    for (int i = 0; i < 3; i++) pushLockBit(i, w);
    t = 1;
    forever begin
      pushCmd(8'h20, 0, 0, 0);
      pushStb(8'hD0, w);
      pushCmd(8'hA0, 0, 0, 0);
      for (int a = 0; a < ENC_N; a++) pushRd(0, a);
      if (t >= needed) begin
        for (int a = 0; a < CODE_N; a++) pushRd(1, a);
        for (int a = 0; a < 3; a++) pushRd(2, a);
        break;
      end
      for (int a = 0; a <= STUCK; a++) pushRd(1, a);
      if (t == MAXT) break;
      t++;
    end
    strobeCycles = 8'(width);
    startErase = 1'b1;
    startLock  = both;
    lockMask   = 3'b111;
    codeLoaded = 1'b1;
    @(negedge clk);
    startErase = 1'b0;
    startLock  = 1'b0;
    check(busy == 1'b1, "R10", "busy after erase request", busy, 1);
    check(done == 1'b0, "R10", "done cleared on accept", done, 0);
    if (both) begin
      strobeCycles = 8'(width + 5);   // R3: change after accept must not matter
      repeat (7) @(negedge clk);
      startLock = 1'b1;                // R9: ignored while busy
      @(negedge clk);
      startLock = 1'b0;
    end
    waitDone();
    if (t >= needed) begin
      check(fail == 1'b0, "R5", "fail after good erase", fail, 0);
      check(int'(eraseTries) == t, "R5", "attempts used", eraseTries, t);
    end else begin
      check(fail == 1'b1, "R6", "fail after retry limit", fail, 1);
      check(int'(eraseTries) == MAXT, "R6", "attempts at limit", eraseTries, MAXT);
    end
    check(busy == 1'b0, "R10", "busy low at done", busy, 0);
    check(expQ.size() == 0, "R2/R4", "operations left unseen", expQ.size(), 0);
  endtask

  task automatic runLock(input logic [2:0] mask, input int width);
    for (int i = 0; i < 3; i++) if (mask[i]) pushLockBit(i, (width == 0) ? 1 : width);
    strobeCycles = 8'(width);
    lockMask   = mask;
    codeLoaded = 1'b1;
    startLock  = 1'b1;
    @(negedge clk);
    startLock = 1'b0;
    waitDone();
    check(fail == 1'b0, "R7", "fail after lock flow", fail, 0);
    check(expQ.size() == 0, "R7", "lock pulses left unseen", expQ.size(), 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(fail == 1'b0, "R1", "fail", fail, 0);
    check(eraseTries == '0, "R1", "eraseTries", eraseTries, 0);
    check({cmdLoad, strobe, rdEn} == 3'b000, "R1", "port strobes", {cmdLoad, strobe, rdEn}, 0);

    runErase(3, 1, 1'b0);     // R2 R4 R5
    runErase(0, 3, 1'b0);     // R3 zero width, R5 several attempts
    runErase(2, 99, 1'b0);    // R6 retry limit

    // R8 rejected lock request
    codeLoaded = 1'b0;
    lockMask   = 3'b111;
    startLock  = 1'b1;
    @(negedge clk);
    startLock = 1'b0;
    check(done == 1'b1, "R8", "done after reject", done, 1);
    check(fail == 1'b1, "R8", "fail after reject", fail, 1);
    check(busy == 1'b0, "R8", "busy after reject", busy, 0);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R8", "queue after reject", expQ.size(), 0);

    runLock(3'b101, 2);       // R7 subset, lowest first

    // R7 empty mask
    codeLoaded = 1'b1;
    lockMask   = 3'b000;
    startLock  = 1'b1;
    @(negedge clk);
    startLock = 1'b0;
    check(done == 1'b1 && fail == 1'b0, "R7", "empty mask done/fail", {done, fail}, 2'b10);
    repeat (5) @(negedge clk);

    runErase(2, 2, 1'b1);     // R9 simultaneous and late requests, R3 latching

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule